// File: doc/BRIEF.md
# Single-Bit Non-Restoring Division Step

This block carries out one iteration of a bit-serial non-restoring divider. In one cycle it takes a partial remainder and a divisor. It shifts the remainder left by one, feeding in a single dividend bit, and then adds or subtracts the divisor. The choice between add and subtract comes from three status bits held in the block: the quotient-sign bit Q, the divisor-sign bit M, and the quotient bit T. The new remainder is produced combinationally. The updated Q and T are captured in the status register on the clock edge of the step.

A surrounding sequencer owns the remainder register, the dividend shifting and the iteration count. It first issues an init, unsigned or signed, to prepare the status bits. It then issues one step per quotient bit. The sequencer can force the bit that is shifted in, which is how the next dividend bit enters while the previous quotient bit leaves through T. Repeating the step W times, and collecting T after each step, yields the unsigned quotient.

Top module: `divstep_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the status outputs q_o, m_o and t_o are all 0.
- R2: An init with init_signed_i=0 clears q_o, m_o and t_o to 0 on the next clock edge.
- R3: An init with init_signed_i=1 loads q_o from bit W-1 of rem_i and m_o from bit W-1 of divisor_i. It sets t_o to q_o XOR m_o. Init takes priority over step_i in the same cycle.
- R4: rem_o is built from rem_i shifted left by one place, with the shift-in bit placed at bit 0. The shift-in bit is the registered T unless t_force_i is 1.
- R5: When the registered Q equals M, rem_o is the shifted value minus divisor_i, modulo 2^W. Otherwise rem_o is the shifted value plus divisor_i, modulo 2^W.
- R6: On a step, the new Q is the XOR of three bits: bit W-1 of rem_i, the borrow (subtract) or carry (add) of the W-bit operation, and M.
- R7: On a step, t_o becomes 1 exactly when the new Q equals M, and m_o is unchanged.
- R8: In a cycle with neither init_i nor step_i, q_o, m_o and t_o hold their values.
- R9: When t_force_i is 1, t_force_val_i replaces the registered T as the shift-in bit, and the registered T itself is not used.
- R10: The following sequence leaves the unsigned quotient of N divided by D (D nonzero) in the collected bit string. First an unsigned init. Then W steps, each with rem_i starting from 0 and taking the previous rem_o, and with the forced shift-in bit taking the dividend bits of N from the most significant bit down. After each step, the new t_o is shifted into the low end of the dividend word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load the status bits this cycle |
| init_signed_i | input | 1 | Init flavour: 1 signed setup, 0 clear all |
| step_i | input | 1 | Perform a step and update Q and T |
| t_force_i | input | 1 | Use t_force_val_i as the shift-in bit |
| t_force_val_i | input | 1 | Forced shift-in bit |
| divisor_i | input | W | Divisor |
| rem_i | input | W | Current partial remainder |
| rem_o | output | W | Next partial remainder (combinational) |
| q_o | output | 1 | Registered Q status bit |
| m_o | output | 1 | Registered M status bit |
| t_o | output | 1 | Registered T status bit |

## Verification
The bench builds the block with W=6 and the default carry variant. This makes every dividend against every nonzero divisor cheap enough to run completely. Each of those 4032 divisions runs six forced-bit steps, and the bench compares the collected quotient with integer division. A set of hand-worked single steps exercises each add/subtract and carry/borrow combination, with M at 0 and at 1. These steps also check that the registers hold between steps and that init has priority over step.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } divstep_status_t;

  localparam int unsigned CARRY_BY_COMPARE = 0;
  localparam int unsigned CARRY_BY_WIDE_ADD = 1;
endpackage

// File: rtl/divstep_core.sv
module divstep_core #(
  parameter int unsigned W = 32,
  parameter int unsigned CARRY_MODE = 1
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] dvs,
  input  logic         q,
  input  logic         m,
  input  logic         shift_in,
  output logic [W-1:0] rem_next,
  output logic         q_next,
  output logic         t_next
);
  localparam int unsigned TOP = W - 1;

  logic [W-1:0] shifted;
  logic         do_sub;
  logic         cy_flag;
  logic         top_bit;

  assign top_bit = rem[TOP];
  assign shifted = {rem[W-2:0], shift_in};
  assign do_sub  = (q == m);

  generate
    if (CARRY_MODE == divstep_pkg::CARRY_BY_WIDE_ADD) begin : g_wide
      logic [W:0] ext;
      always_comb begin
        if (do_sub) ext = {1'b0, shifted} - {1'b0, dvs};
        else        ext = {1'b0, shifted} + {1'b0, dvs};
      end
      assign rem_next = ext[W-1:0];
      assign cy_flag  = ext[W];
    end else begin : g_cmp
      logic [W-1:0] res;
      always_comb begin
        if (do_sub) res = shifted - dvs;
        else        res = shifted + dvs;
      end
      assign rem_next = res;
      assign cy_flag  = do_sub ? (res > shifted) : (res < shifted);
    end
  endgenerate

  assign q_next = top_bit ^ cy_flag ^ m;
  assign t_next = (q_next == m);
endmodule

// File: rtl/divstep_status.sv
module divstep_status #(
  parameter int unsigned W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init,
  input  logic                        init_signed,
  input  logic                        step,
  input  logic [W-1:0]                rem_in,
  input  logic [W-1:0]                dvs_in,
  input  logic                        q_step,
  input  logic                        t_step,
  output divstep_pkg::divstep_status_t st
);
  localparam int unsigned TOP = W - 1;

  divstep_pkg::divstep_status_t st_d;
  logic                         st_en;

  always_comb begin
    st_d  = st;
    st_en = 1'b0;
    if (init) begin
      st_en = 1'b1;
      if (init_signed) begin
        st_d.q = rem_in[TOP];
        st_d.m = dvs_in[TOP];
        st_d.t = rem_in[TOP] ^ dvs_in[TOP];
      end else begin
        st_d = '0;
      end
    end else if (step) begin
      st_en  = 1'b1;
      st_d.q = q_step;
      st_d.t = t_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (st_en) begin
      st <= st_d;
    end
  end
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit #(
  parameter int unsigned W = 32,
  parameter int unsigned CARRY_MODE = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init_i,
  input  logic         init_signed_i,
  input  logic         step_i,
  input  logic         t_force_i,
  input  logic         t_force_val_i,
  input  logic [W-1:0] divisor_i,
  input  logic [W-1:0] rem_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o
);
  divstep_pkg::divstep_status_t st;
  logic shift_bit;
  logic q_step;
  logic t_step;

  assign shift_bit = t_force_i ? t_force_val_i : st.t;

  divstep_core #(.W(W), .CARRY_MODE(CARRY_MODE)) u_core (
    .rem      (rem_i),
    .dvs      (divisor_i),
    .q        (st.q),
    .m        (st.m),
    .shift_in (shift_bit),
    .rem_next (rem_o),
    .q_next   (q_step),
    .t_next   (t_step)
  );

  divstep_status #(.W(W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (init_i),
    .init_signed (init_signed_i),
    .step        (step_i),
    .rem_in      (rem_i),
    .dvs_in      (divisor_i),
    .q_step      (q_step),
    .t_step      (t_step),
    .st          (st)
  );

  assign q_o = st.q;
  assign m_o = st.m;
  assign t_o = st.t;
endmodule

// File: rtl/divstep_chk.sv
module divstep_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         init_i,
  input logic         init_signed_i,
  input logic         step_i,
  input logic [W-1:0] divisor_i,
  input logic [W-1:0] rem_i,
  input logic         q_o,
  input logic         m_o,
  input logic         t_o
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i) |=> ($stable(q_o) && $stable(m_o) && $stable(t_o)));

  assert_t_tracks_q_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i) |=> (t_o == (q_o == m_o)));

  assert_m_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i) |=> $stable(m_o));

  assert_clear_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && !init_signed_i) |=> (!q_o && !m_o && !t_o));

  assert_signed_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_i && init_signed_i) |=>
      (q_o == $past(rem_i[W-1]) && m_o == $past(divisor_i[W-1]) && t_o == (q_o ^ m_o)));
endmodule

bind divstep_unit divstep_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_i        (init_i),
  .init_signed_i (init_signed_i),
  .step_i        (step_i),
  .divisor_i     (divisor_i),
  .rem_i         (rem_i),
  .q_o           (q_o),
  .m_o           (m_o),
  .t_o           (t_o)
);

// File: tb/sim_divstep_unit.sv
`timescale 1ns/100ps
module sim_divstep_unit;
  localparam int unsigned W = 6;
  localparam int unsigned LIM = 1 << W;

  logic         clk;
  logic         rst_n;
  logic         init_i, init_signed_i, step_i, t_force_i, t_force_val_i;
  logic [W-1:0] divisor_i, rem_i, rem_o;
  logic         q_o, m_o, t_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  divstep_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .init_signed_i(init_signed_i),
    .step_i(step_i), .t_force_i(t_force_i), .t_force_val_i(t_force_val_i),
    .divisor_i(divisor_i), .rem_i(rem_i), .rem_o(rem_o),
    .q_o(q_o), .m_o(m_o), .t_o(t_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    init_i = 0; init_signed_i = 0; step_i = 0; t_force_i = 0; t_force_val_i = 0;
  endtask

  // drive at negedge, clock once, return at next negedge
  task automatic do_init(input bit sgn, input int r, input int d);
    idle(); init_i = 1; init_signed_i = sgn; rem_i = W'(r); divisor_i = W'(d);
    @(negedge clk); idle();
  endtask

  task automatic do_step(input int r, input int d, input bit frc, input bit fv, output int ro);
    idle(); step_i = 1; t_force_i = frc; t_force_val_i = fv;
    rem_i = W'(r); divisor_i = W'(d);
    #1 ro = int'(rem_o);
    @(negedge clk); idle();
  endtask

  task automatic check_st(input string req, input int q, input int m, input int t);
    check(req, {29'd0, q_o, m_o, t_o}, (q << 2) | (m << 1) | t);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ro;
    idle(); rem_i = '0; divisor_i = '0;
    rst_n = 0;
    #1 check_st("R1 in reset", 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_st("R1 after reset", 0, 0, 0);

    // signed init: rem msb 1, divisor msb 0
    do_init(1, 40, 3);
    check_st("R3 signed init", 1, 0, 1);
    // R2 clear
    do_init(0, 63, 63);
    check_st("R2 unsigned init", 0, 0, 0);
    // R3 init priority over step
    idle(); init_i = 1; init_signed_i = 1; step_i = 1; rem_i = 6'd0; divisor_i = 6'd48;
    @(negedge clk); idle();
    check_st("R3 init over step", 0, 1, 1);

    // Subtract with borrow: Q=M=0, T=0, rem=33, D=5 -> 61, q=0 t=1
    do_init(0, 0, 0);
    do_step(33, 5, 0, 0, ro);
    check("R5 R4 sub borrow rem", ro, 61);
    check_st("R6 R7 sub borrow status", 0, 0, 1);
    // R8 hold
    repeat (3) @(negedge clk);
    check_st("R8 hold", 0, 0, 1);
    // Subtract no borrow, T=1 shifted in: rem=10, D=3 -> 18
    do_step(10, 3, 0, 0, ro);
    check("R4 R5 sub noborrow rem", ro, 18);
    check_st("R6 sub noborrow status", 0, 0, 1);
    // R9 forced 0 in place of T=1: rem=10,D=3 -> 20-3=17
    do_step(10, 3, 1, 0, ro);
    check("R9 forced bit rem", ro, 17);

    // Add, no carry: Q=1,M=0,T=1, rem=7, D=3 -> 18, q=0 t=1
    do_init(1, 40, 3);
    do_step(7, 3, 0, 0, ro);
    check("R5 add nocarry rem", ro, 18);
    check_st("R6 add nocarry status", 0, 0, 1);
    // Add with carry: rem=30, D=60 -> 57, q=1 t=0
    do_init(1, 40, 3);
    do_step(30, 60, 0, 0, ro);
    check("R5 add carry rem", ro, 57);
    check_st("R6 R7 add carry status", 1, 0, 0);
    // M=1 add: Q=0,M=1,T=1, rem=5, D=48 -> 59, q=1 t=1
    do_init(1, 0, 48);
    do_step(5, 48, 0, 0, ro);
    check("R5 m1 add rem", ro, 59);
    check_st("R6 R7 m1 status", 1, 1, 1);

    // R10 exhaustive unsigned division
    for (int d = 1; d < LIM; d++) begin
      for (int n = 0; n < LIM; n++) begin
        int rem, word;
        bit tb;
        do_init(0, 0, d);
        rem = 0; word = n;
        for (int i = 0; i < W; i++) begin
          tb = word[W-1];
          word = ((word << 1) | int'(t_o)) & (LIM - 1);
          do_step(rem, d, 1, tb, rem);
        end
        word = ((word << 1) | int'(t_o)) & (LIM - 1);
        check($sformatf("R10 quotient %0d/%0d", n, d), word, n / d);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule